// File: doc/BRIEF.md
# Banked Memory Conflict Serializer

This block takes one access group from a set of lanes and carries it out against an interleaved multi-bank memory that it holds itself. Each lane offers a valid bit, an address and write data. One direction flag applies to the whole group, so a group is all reads or all writes. An address is placed in the bank given by its low bits, which is the address modulo the lane count. The bank count equals the lane count.

Lanes that name the same address are folded into a single request. The block then counts the distinct requests that land on each bank. The largest of these counts is the congestion. It is exported, and it sets exactly how many issue slots the group takes. In each slot every bank accepts at most one request. Requests then move through a bank pipeline of fixed depth. When a group of reads finishes, each valid lane holds the word at its own address, including lanes whose request was folded into another lane's. When several lanes write one address, the lowest-numbered of them is the one written.

Top module: `bank_serializer`

## Requirements
- R1: After reset, busy and done are low and congestion is 0.
- R2: A word written to address a is stored in bank (a mod LANES), at row (a div LANES). A later read of a returns that word.
- R3: Once a group is captured, congestion equals the largest number of distinct valid addresses that share a bank. It is 0 when no lane is valid.
- R4: The group is issued over exactly congestion slots, and no bank receives more than one request in any slot.
- R5: done is a single-cycle pulse. It appears congestion+LAT clock edges after the edge that captured start, or 1 edge after it when no lane is valid. busy is low whenever done is high.
- R6: When done rises after a read group, every valid lane's output carries the word stored at its address. This includes lanes whose address duplicated a lower lane's.
- R7: When several valid lanes write one address in the same group, the word from the lowest-indexed of them is stored, and the others are dropped.
- R8: A start raised while busy is ignored. It does not change the running group, its timing or the memory, and congestion stays stable while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Captures a new group when the block is idle |
| wr_en | input | 1 | Group direction: 1 = write, 0 = read |
| lane_valid | input | LANES | Per-lane request valid |
| lane_addr | input | LANES*AW | Per-lane word address, lane i in bits [i*AW +: AW] |
| lane_wdata | input | LANES*DW | Per-lane write data |
| busy | output | 1 | A group is being issued or drained |
| done | output | 1 | One-cycle pulse when the last slot has left the pipeline |
| congestion | output | $clog2(LANES+1) | Slots used by the captured group |
| lane_rdata | output | LANES*DW | Per-lane read data, valid from the done cycle |

## Verification
The hardest case to reach is a read group that mixes folded duplicates with several distinct addresses in one bank. There, a lane that was never itself issued must still pick up its data in the slot of the lane that represents it. The bench drives thousands of address tuples built from counter digits, so that duplicates, same-bank collisions and masked lanes all occur together. It compares every lane with an address-level model.

Write groups built from a repeated address, from strided addresses or from pairs are each followed by a read of the same addresses, which exposes which lane won. Some groups also raise a stray write start in mid-flight, and the bench then checks that neither the timing nor the memory moved.

// File: rtl/bank_serializer.sv
`timescale 1ns/1ps
module bank_serializer #(
  parameter int LANES = 4,
  parameter int AW    = 4,
  parameter int DW    = 8,
  parameter int LAT   = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       wr_en,
  input  logic [LANES-1:0]           lane_valid,
  input  logic [LANES*AW-1:0]        lane_addr,
  input  logic [LANES*DW-1:0]        lane_wdata,
  output logic                       busy,
  output logic                       done,
  output logic [$clog2(LANES+1)-1:0] congestion,
  output logic [LANES*DW-1:0]        lane_rdata
);
  localparam int BW    = $clog2(LANES);
  localparam int CW    = $clog2(LANES+1);
  localparam int RW    = AW - BW;
  localparam int DEPTH = 1 << RW;
  localparam int TW    = $clog2(LAT) + 1;

  typedef enum logic [1:0] {IDLE, ISSUE, DRAIN} state_t;
  state_t state;

  logic [LANES-1:0]   v_q;
  logic               wr_q;
  logic [AW-1:0]      a_q [LANES];
  logic [DW-1:0]      d_q [LANES];
  logic [DW-1:0]      mem [LANES][DEPTH];
  logic [LANES-1:0]   uniq, issue_mask;
  logic [BW-1:0]      rep  [LANES];
  logic [CW-1:0]      rank [LANES];
  logic [CW-1:0]      load [LANES];
  logic [CW-1:0]      cong, slot;
  logic [TW-1:0]      cnt;
  logic [LANES-1:0]   pipe [LAT];
  logic [LANES*BW-1:0] lane_bank_f;

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      uniq[i] = v_q[i];
      rep[i]  = BW'(i);
      for (int j = i - 1; j >= 0; j--)
        if (v_q[j] && a_q[j] == a_q[i]) begin
          uniq[i] = 1'b0;
          rep[i]  = BW'(j);
        end
    end
  end

  always_comb begin
    cong = '0;
    for (int b = 0; b < LANES; b++) load[b] = '0;
    for (int i = 0; i < LANES; i++) begin
      rank[i] = '0;
      for (int j = 0; j < i; j++)
        if (uniq[j] && a_q[j][BW-1:0] == a_q[i][BW-1:0]) rank[i] = rank[i] + CW'(1);
      if (uniq[i]) load[a_q[i][BW-1:0]] = load[a_q[i][BW-1:0]] + CW'(1);
    end
    for (int b = 0; b < LANES; b++)
      if (load[b] > cong) cong = load[b];
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      issue_mask[i] = (state == ISSUE) && uniq[i] && (rank[i] == slot);
      lane_bank_f[i*BW +: BW] = a_q[i][BW-1:0];
    end
  end

  assign busy       = (state != IDLE);
  assign congestion = cong;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= IDLE;
      v_q   <= '0;
      wr_q  <= 1'b0;
      slot  <= '0;
      cnt   <= '0;
      done  <= 1'b0;
      for (int k = 0; k < LAT; k++) pipe[k] <= '0;
      for (int i = 0; i < LANES; i++) begin
        a_q[i] <= '0;
        d_q[i] <= '0;
      end
    end else begin
      done    <= 1'b0;
      pipe[0] <= issue_mask;
      for (int k = 1; k < LAT; k++) pipe[k] <= pipe[k-1];
      case (state)
        IDLE:
          if (start) begin
            state <= ISSUE;
            slot  <= '0;
            v_q   <= lane_valid;
            wr_q  <= wr_en;
            for (int i = 0; i < LANES; i++) begin
              a_q[i] <= lane_addr[i*AW +: AW];
              d_q[i] <= lane_wdata[i*DW +: DW];
            end
          end
        ISSUE:
          if (cong == '0) begin
            done  <= 1'b1;
            state <= IDLE;
          end else if (slot == cong - CW'(1)) begin
            state <= DRAIN;
            cnt   <= '0;
          end else begin
            slot <= slot + CW'(1);
          end
        DRAIN:
          if (cnt == TW'(LAT - 1)) begin
            done  <= 1'b1;
            state <= IDLE;
          end else begin
            cnt <= cnt + TW'(1);
          end
        default: state <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++)
      if (wr_q && pipe[LAT-1][i])
        mem[a_q[i][BW-1:0]][a_q[i][AW-1:BW]] <= d_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lane_rdata <= '0;
    else
      for (int k = 0; k < LANES; k++)
        if (!wr_q && v_q[k] && pipe[LAT-1][rep[k]])
          lane_rdata[k*DW +: DW] <= mem[a_q[k][BW-1:0]][a_q[k][AW-1:BW]];
  end
endmodule

// File: rtl/bank_serializer_chk.sv
`timescale 1ns/1ps
module bank_serializer_chk #(
  parameter int LANES = 4,
  parameter int BW    = 2,
  parameter int CW    = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                busy,
  input logic                done,
  input logic [CW-1:0]       congestion,
  input logic [LANES-1:0]    issue_mask,
  input logic [LANES*BW-1:0] lane_bank
);
  // R3
  cong_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    congestion <= CW'(LANES));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R8
  cong_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(congestion));

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    logic [LANES-1:0] hit;
    always_comb
      for (int i = 0; i < LANES; i++)
        hit[i] = issue_mask[i] && (lane_bank[i*BW +: BW] == BW'(b));
    // R4
    one_per_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(hit) <= 1);
  end
endmodule

bind bank_serializer bank_serializer_chk #(.LANES(LANES), .BW(BW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .congestion(congestion),
  .issue_mask(issue_mask), .lane_bank(lane_bank_f));

// File: tb/bank_serializer_test.sv
`timescale 1ns/1ps
module bank_serializer_test;
  logic        clk = 0, rst_n = 0, start = 0, wr_en = 0;
  logic [3:0]  lane_valid = '0;
  logic [15:0] lane_addr = '0;
  logic [31:0] lane_wdata = '0;
  logic        busy, done;
  logic [2:0]  congestion;
  logic [31:0] lane_rdata;
  int checks = 0, failures = 0;
  logic [7:0] mm [16];

  bank_serializer #(.LANES(4), .AW(4), .DW(8), .LAT(3)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .wr_en(wr_en), .lane_valid(lane_valid),
    .lane_addr(lane_addr), .lane_wdata(lane_wdata), .busy(busy), .done(done),
    .congestion(congestion), .lane_rdata(lane_rdata));

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_cong(input logic [3:0] vm, input logic [15:0] ad);
    int ld [4];
    int m;
    bit dup;
    m = 0;
    for (int b = 0; b < 4; b++) ld[b] = 0;
    for (int i = 0; i < 4; i++) begin
      dup = 0;
      for (int j = 0; j < i; j++)
        if (vm[j] && vm[i] && ad[j*4 +: 4] == ad[i*4 +: 4]) dup = 1;
      if (vm[i] && !dup) ld[ad[i*4 +: 2]]++;
    end
    for (int b = 0; b < 4; b++) if (ld[b] > m) m = ld[b];
    return m;
  endfunction

  task automatic run_grp(input logic w, input logic [3:0] vm, input logic [15:0] ad,
                         input logic [31:0] wd, input bit poke);
    int lat, c, e;
    c = exp_cong(vm, ad);
    e = (c == 0) ? 1 : c + 3;
    wr_en = w; lane_valid = vm; lane_addr = ad; lane_wdata = wd; start = 1;
    @(posedge clk); #1 start = 0;
    lat = 0;
    while (lat < 40) begin
      @(posedge clk); lat++;
      if (poke && lat == 2) begin
        #1 start = 1; wr_en = 1; lane_valid = 4'hF; lane_addr = ~ad; lane_wdata = 32'hA5A5A5A5;
      end
      if (poke && lat == 3) begin
        #1 start = 0;
      end
      @(negedge clk);
      if (done) break;
    end
    start = 0;
    check(lat == e, poke ? "R8 R5 done latency with stray start" : "R4 R5 done latency", lat, e);
    check(int'(congestion) == c, "R3 congestion", congestion, c);
    if (w) begin
      for (int i = 0; i < 4; i++) begin
        bit dup = 0;
        for (int j = 0; j < i; j++) if (vm[j] && ad[j*4 +: 4] == ad[i*4 +: 4]) dup = 1;
        if (vm[i] && !dup) mm[ad[i*4 +: 4]] = wd[i*8 +: 8];
      end
    end else begin
      for (int i = 0; i < 4; i++)
        if (vm[i])
          check(lane_rdata[i*8 +: 8] == mm[ad[i*4 +: 4]], "R6 R2 lane read data",
                lane_rdata[i*8 +: 8], mm[ad[i*4 +: 4]]);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(!busy, "R1 busy after reset", busy, 0);
    check(!done, "R1 done after reset", done, 0);
    check(congestion == 0, "R1 congestion after reset", congestion, 0);
    rst_n = 1;
    @(negedge clk);
    // R2: fill every word with contiguous row writes
    for (int r = 0; r < 4; r++) begin
      logic [15:0] ad;
      logic [31:0] wd;
      for (int i = 0; i < 4; i++) begin
        ad[i*4 +: 4] = 4'(r*4 + i);
        wd[i*8 +: 8] = 8'((r*4 + i)*13 + 5);
      end
      run_grp(1'b1, 4'hF, ad, wd, 1'b0);
    end
    // R3 R4 R6 R8: read sweep
    for (int n = 0; n < 4096; n++) begin
      logic [15:0] ad;
      ad[3:0] = 4'(n); ad[7:4] = 4'(n >> 4); ad[11:8] = 4'(n >> 8); ad[15:12] = 4'(n*5 + 3);
      run_grp(1'b0, 4'(n ^ (n >> 8)), ad, 32'h0, (n % 8) == 0);
    end
    // R7: writes with repeated, strided and paired addresses, then read back
    for (int n = 0; n < 512; n++) begin
      logic [15:0] ad;
      logic [31:0] wd;
      int mode;
      mode = n % 3;
      for (int i = 0; i < 4; i++) begin
        ad[i*4 +: 4] = 4'((n % 16) + (mode == 1 ? 4*i : (mode == 2 ? (i >> 1)*5 : 0)));
        wd[i*8 +: 8] = 8'(n*4 + i + 1);
      end
      run_grp(1'b1, 4'((n*7) >> 3), ad, wd, (n % 5) == 0);
      run_grp(1'b0, 4'hF, ad, 32'h0, 1'b0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule